// File: doc/BRIEF.md
# Descriptor-Driven Configuration Data Mover

This block holds a small set of read-only configuration items and copies bytes from them into system memory on request. Software first picks an item through a selector register; selecting an item rewinds its read position to zero. It then hands the engine the memory address of a 16-byte descriptor by writing a 64-bit pointer register. The pointer is written as two 32-bit halves, and the write to the low half starts the operation.

After the start, the engine reads the descriptor over a memory master port. The descriptor holds a control word, a byte count and a 64-bit destination address. The engine then copies bytes from the selected item, or only advances the read position, or does nothing. At the end it overwrites the descriptor's control word with a completion status and clears the pointer register. A feature register tells software that this descriptor path is present.

Top module: `cfgdma_engine`

## Requirements
- R1: Register word 0 is read-only and reads 0x00000002. Bit 1 set means the descriptor path is present.
- R2: Register words 2 (high half) and 3 (low half) hold the 64-bit descriptor pointer in big-endian lane order: bus byte lane 0 (bits 7:0) carries the most significant byte of the half. Both halves read as zero after reset.
- R3: A write to word 3 starts an operation. A write to word 2 only loads the high half. The pointer used is {high half, written low half}, with address bits 1:0 forced to zero.
- R4: The engine reads the descriptor as four 32-bit words, each a single read beat. The words are, in address order: control at pointer+0, length at +4, destination high at +8, destination low at +12. Each word is big-endian, so memory byte lane 0 is the most significant byte.
- R5: When control bit 1 (read) is set, the engine copies length bytes to destination, destination+1, and so on. Each byte is one write beat: the enable is 1 << address[1:0], and the byte is replicated on all four lanes. Item i has length ITEM_BYTES − i·(ITEM_BYTES/NUM_ITEMS). Its byte k is ((64·i) xor (3·k) xor 0x5A) mod 256.
- R6: Each copied byte advances the item read position by one. A byte read at or past the end of the item, or from a selector value of NUM_ITEMS or more, is 0x00 and raises no error.
- R7: When control bit 2 (skip) is set and bit 1 is clear, the read position advances by length and no data write is issued. Control bit 0 in a fetched descriptor has no effect.
- R8: On completion, the engine writes the control word at pointer+0 as zero with all four byte enables, and both pointer halves then read as zero.
- R9: An error response on any fetch or data beat ends the transfer. The control word is then written as big-endian 1 (memory bytes 00 00 00 01). The byte whose write failed still counts as consumed.
- R10: Writing register word 1 selects an item from bits 7:0 and resets the read position to zero. Word 1 reads back the selector.
- R11: While an operation is in progress, writes to words 1, 2 and 3 are ignored.
- R12: Every memory request is held stable, with valid asserted, until ready is seen. One request is outstanding at a time, and each request is answered by one response beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Response beat |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Bus error on this beat |

## Verification
The bench uses the default parameters: four items of 16, 12, 8 and 4 bytes, and an 8-bit selector. With these, selector values 4 and 5 address no item, and lengths up to 24 run well past the shorter items. Together with pointer high halves that are nonzero, memory targets that respond with an error, and random stalls on ready and on the response, this covers the zero-fill past the end, the 64-bit pointer path, the early status write after an error, and the handshake hold.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int          PTR_W    = 64;
  localparam logic [31:0] FEAT_VAL = 32'h0000_0002;
  localparam int          CTL_READ = 1;
  localparam int          CTL_SKIP = 2;

  typedef enum logic [1:0] {
    RA_FEATURE = 2'd0,
    RA_SELECT  = 2'd1,
    RA_PTR_HI  = 2'd2,
    RA_PTR_LO  = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FETCH_WAIT, S_COPY, S_COPY_WAIT, S_STATUS, S_STATUS_WAIT
  } xfer_state_e;

  // swap byte order between bus lanes and a big-endian value
  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // length in bytes of an item; selectors beyond the store are empty
  function automatic int unsigned item_len(input int unsigned sel, input int unsigned n,
                                           input int unsigned b);
    if (sel < n) return b - sel * (b / n);
    return 0;
  endfunction

  // content of one item byte
  function automatic logic [7:0] item_byte(input int unsigned sel, input int unsigned off);
    return 8'((sel << 6) ^ (off * 3) ^ 32'h5A);
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] a);
    return 4'b0001 << a;
  endfunction
endpackage

// File: rtl/cfgdma_item_store.sv
module cfgdma_item_store
  import cfgdma_pkg::*;
#(
  parameter int NUM_ITEMS  = 4,
  parameter int ITEM_BYTES = 16,
  parameter int SEL_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             adv,
  input  logic             skip_en,
  input  logic [31:0]      skip_len,
  output logic [SEL_W-1:0] sel_q,
  output logic [31:0]      off_q,
  output logic [7:0]       byte_out
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IDX_W = (NUM_ITEMS  > 1) ? $clog2(NUM_ITEMS)  : 1;
  localparam int OFF_W = (ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1;

  logic [7:0] store_q [NUM_ITEMS][ITEM_BYTES];

  for (genvar gi = 0; gi < NUM_ITEMS; gi++) begin : g_item
    for (genvar gk = 0; gk < ITEM_BYTES; gk++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q[gi][gk] <= item_byte(gi, gk);
        else        store_q[gi][gk] <= store_q[gi][gk];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= '0;
    end else if (sel_wr) begin
      sel_q <= sel_wdata;
      off_q <= '0;
    end else if (skip_en) begin
      off_q <= off_q + skip_len;
    end else if (adv) begin
      off_q <= off_q + 32'd1;
    end
  end

  logic [31:0] cur_len;
  logic        in_range;
  assign cur_len  = 32'(item_len(32'(sel_q), NUM_ITEMS, ITEM_BYTES));
  assign in_range = (32'(sel_q) < NUM_ITEMS) && (off_q < cur_len);
  assign byte_out = in_range ? store_q[sel_q[IDX_W-1:0]][off_q[OFF_W-1:0]] : 8'h00;

  p_sel_clears_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> off_q == 32'd0);
  p_offset_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !sel_wr && !skip_en |=> off_q == $past(off_q) + 32'd1);
  p_skip_adds_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_en && !sel_wr |=> off_q == $past(off_q) + $past(skip_len));
endmodule

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
  import cfgdma_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [SEL_W-1:0] sel_q,
  output logic             sel_wr,
  output logic [SEL_W-1:0] sel_wdata,
  output logic             start,
  output logic [PTR_W-1:0] start_ptr
);
  timeunit 1ns; timeprecision 1ps;

  logic [PTR_W-1:0] ptr_q;
  logic             wr_ok;

  assign wr_ok     = reg_wr && !busy;
  assign sel_wr    = wr_ok && (reg_addr == RA_SELECT);
  assign sel_wdata = reg_wdata[SEL_W-1:0];
  assign start     = wr_ok && (reg_addr == RA_PTR_LO);
  assign start_ptr = {ptr_q[PTR_W-1:32], bswap32(reg_wdata)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (done) begin
      ptr_q <= '0;
    end else if (wr_ok && reg_addr == RA_PTR_HI) begin
      ptr_q[PTR_W-1:32] <= bswap32(reg_wdata);
    end else if (start) begin
      ptr_q[31:0] <= bswap32(reg_wdata);
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_FEATURE: reg_rdata = FEAT_VAL;
      RA_SELECT:  reg_rdata = 32'(sel_q);
      RA_PTR_HI:  reg_rdata = bswap32(ptr_q[PTR_W-1:32]);
      default:    reg_rdata = bswap32(ptr_q[31:0]);
    endcase
  end

  p_ptr_zero_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ptr_q == '0);
  p_busy_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(ptr_q));
endmodule

// File: rtl/cfgdma_xfer.sv
module cfgdma_xfer
  import cfgdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [7:0]       byte_in,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [PTR_W-1:0] req_addr,
  output logic [31:0]      req_wdata,
  output logic [3:0]       req_be,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_rdata,
  input  logic             rsp_err,
  output logic             busy,
  output logic             done,
  output logic             byte_adv,
  output logic             skip_en,
  output logic [31:0]      skip_len
);
  timeunit 1ns; timeprecision 1ps;

  xfer_state_e      st_q;
  logic [PTR_W-1:0] desc_q, tgt_q;
  logic [31:0]      len_q, cnt_q;
  logic [1:0]       widx_q;
  logic             rd_q, sk_q, err_q;

  logic             hs, rsp_ok, rsp_bad, last_word;
  logic [31:0]      fld;
  logic [PTR_W-1:0] copy_addr;

  assign hs        = req_valid && req_ready;
  assign rsp_ok    = rsp_valid && !rsp_err;
  assign rsp_bad   = rsp_valid && rsp_err;
  assign fld       = bswap32(rsp_rdata);
  assign copy_addr = tgt_q + PTR_W'(cnt_q);
  assign last_word = (st_q == S_FETCH_WAIT) && (widx_q == 2'd3) && rsp_ok;

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_STATUS_WAIT) && rsp_valid;
  assign byte_adv = (st_q == S_COPY) && hs;
  assign skip_en  = last_word && !rd_q && sk_q;
  assign skip_len = len_q;

  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = desc_q;
    req_wdata = '0;
    req_be    = 4'h0;
    unique case (st_q)
      S_FETCH: begin
        req_valid = 1'b1;
        req_addr  = desc_q + PTR_W'({widx_q, 2'b00});
      end
      S_COPY: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = copy_addr;
        req_wdata = {4{byte_in}};
        req_be    = lane_mask(copy_addr[1:0]);
      end
      S_STATUS: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_wdata = bswap32({31'd0, err_q});
        req_be    = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      desc_q <= '0;
      tgt_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      widx_q <= '0;
      rd_q   <= 1'b0;
      sk_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          desc_q <= start_ptr & ~PTR_W'(3);
          widx_q <= '0;
          err_q  <= 1'b0;
          st_q   <= S_FETCH;
        end
        S_FETCH: if (hs) st_q <= S_FETCH_WAIT;
        S_FETCH_WAIT: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            st_q  <= S_STATUS;
          end else if (rsp_ok) begin
            widx_q <= widx_q + 2'd1;
            unique case (widx_q)
              2'd0: begin rd_q <= fld[CTL_READ]; sk_q <= fld[CTL_SKIP]; end
              2'd1: len_q <= fld;
              2'd2: tgt_q[PTR_W-1:32] <= fld;
              default: tgt_q[31:0] <= fld;
            endcase
            if (widx_q == 2'd3) begin
              cnt_q <= '0;
              st_q  <= (rd_q && len_q != 32'd0) ? S_COPY : S_STATUS;
            end else begin
              st_q <= S_FETCH;
            end
          end
        end
        S_COPY: if (hs) st_q <= S_COPY_WAIT;
        S_COPY_WAIT: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            st_q  <= S_STATUS;
          end else if (rsp_ok) begin
            cnt_q <= cnt_q + 32'd1;
            st_q  <= (cnt_q + 32'd1 == len_q) ? S_STATUS : S_COPY;
          end
        end
        S_STATUS: if (hs) st_q <= S_STATUS_WAIT;
        default: if (rsp_valid) st_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                               && $stable(req_be) && $stable(req_write));
  p_err_to_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bad && (st_q == S_FETCH_WAIT || st_q == S_COPY_WAIT) |=> st_q == S_STATUS && err_q);
  p_skip_no_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_en |=> st_q == S_STATUS);
  p_copy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_COPY |-> cnt_q < len_q);
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int NUM_ITEMS  = 4,
  parameter int ITEM_BYTES = 16,
  parameter int SEL_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [63:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  output logic [3:0]  mem_req_be,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        mem_rsp_err
);
  timeunit 1ns; timeprecision 1ps;

  logic             done, start, sel_wr, byte_adv, skip_en;
  logic [SEL_W-1:0] sel_q, sel_wdata;
  logic [PTR_W-1:0] start_ptr;
  logic [31:0]      off_q, skip_len;
  logic [7:0]       item_byte_w;

  cfgdma_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .sel_q(sel_q), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .start(start), .start_ptr(start_ptr)
  );

  cfgdma_item_store #(.NUM_ITEMS(NUM_ITEMS), .ITEM_BYTES(ITEM_BYTES), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .adv(byte_adv), .skip_en(skip_en), .skip_len(skip_len),
    .sel_q(sel_q), .off_q(off_q), .byte_out(item_byte_w)
  );

  cfgdma_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .byte_in(item_byte_w),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata), .req_be(mem_req_be),
    .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata), .rsp_err(mem_rsp_err),
    .busy(busy), .done(done), .byte_adv(byte_adv), .skip_en(skip_en), .skip_len(skip_len)
  );

  p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_no_select_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sel_wr);
  p_idle_offset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !sel_wr |=> $stable(off_q));
endmodule

// File: tb/test_cfgdma_engine.sv
module test_cfgdma_engine;
  timeunit 1ns; timeprecision 1ps;
  import cfgdma_pkg::*;

  localparam int NI = 4, IB = 16, SW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        mem_rsp_err = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  cfgdma_engine #(.NUM_ITEMS(NI), .ITEM_BYTES(IB), .SEL_W(SW)) i_cfgdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err)
  );

  int unsigned n_chk = 0, n_fail = 0;
  logic [7:0]  bmem [4096];
  int unsigned wr_count = 0, viol = 0;
  logic [63:0] first_addr = '0;
  bit          first_seen = 1'b0;
  int unsigned b_sel = 0, b_off = 0;

  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // item content as stated in R5/R6
  function automatic logic [7:0] m_byte(input int unsigned s, input int unsigned o);
    if (s < NI && o < IB - s * (IB / NI)) return 8'(((s * 64) ^ (o * 3) ^ 32'h5A) & 32'hFF);
    return 8'h00;
  endfunction

  // memory responder: random ready, random latency, error above address bit 16
  initial begin : responder
    bit pend = 0; int lat = 0; bit last_wait = 0;
    logic [63:0] la = '0; logic [31:0] lw = '0; logic [3:0] lb = '0;
    forever begin
      @(posedge clk);
      if (last_wait && (!mem_req_valid || mem_req_addr !== la || mem_req_wdata !== lw
                        || mem_req_be !== lb)) viol++;
      last_wait = mem_req_valid && !mem_req_ready;
      la = mem_req_addr; lw = mem_req_wdata; lb = mem_req_be;
      if (pend) begin
        mem_req_ready <= 1'b0;
        if (lat == 0) begin mem_rsp_valid <= 1'b1; pend = 0; end
        else lat--;
      end else begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
          logic [11:0] a; a = {mem_req_addr[11:2], 2'b00};
          if (!first_seen) begin first_addr = mem_req_addr; first_seen = 1; end
          mem_rsp_err <= mem_req_addr[16];
          if (mem_req_write) begin
            wr_count++;
            if (!mem_req_addr[16])
              for (int k = 0; k < 4; k++)
                if (mem_req_be[k]) bmem[a + 12'(k)] = mem_req_wdata[8*k +: 8];
            mem_rsp_rdata <= '0;
          end else begin
            mem_rsp_rdata <= {bmem[a + 12'd3], bmem[a + 12'd2], bmem[a + 12'd1], bmem[a]};
          end
          pend = 1; lat = int'($urandom % 3);
          mem_req_ready <= 1'b0;
        end else begin
          mem_req_ready <= rst_n && (($urandom % 4) != 0);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_be(input logic [63:0] p, input logic [31:0] v);
    for (int k = 0; k < 4; k++) bmem[12'(p) + 12'(k)] = v[31 - 8*k -: 8];
  endtask

  task automatic set_sel(input int unsigned s);
    logic [31:0] r;
    reg_write(RA_SELECT, s);
    b_sel = s & 32'hFF; b_off = 0;
    reg_read(RA_SELECT, r);
    chk("R10 selector readback", r, 64'(b_sel));
  endtask

  task automatic run_op(input logic [63:0] p, input logic [31:0] ctl, input logic [31:0] len,
                        input logic [63:0] tgt, input bit poke);
    logic [31:0] r; bit is_err; int unsigned exp_wr; logic [31:0] st;
    put_be(p, ctl); put_be(p + 4, len); put_be(p + 8, tgt[63:32]); put_be(p + 12, tgt[31:0]);
    for (int i = 0; i < int'(len); i++) bmem[12'(tgt) + 12'(i)] = 8'hEE;
    wr_count = 0; first_seen = 0;
    if (p[63:32] != 0) reg_write(RA_PTR_HI, sw32(p[63:32]));
    reg_write(RA_PTR_LO, sw32(p[31:0]));
    if (poke) begin
      chk("R11 busy during poke", 64'(busy), 64'd1);
      reg_write(RA_PTR_LO, 32'h3412_0000);
      reg_write(RA_SELECT, 32'd3);
      reg_read(RA_SELECT, r);
      chk("R11 selector held while busy", r, 64'(b_sel));
    end
    while (busy) @(negedge clk);
    is_err = tgt[16] && ctl[1] && len != 0;
    if (ctl[1]) begin
      if (is_err) begin
        b_off += 1; exp_wr = 2;
        chk("R9 no data stored on error", 64'(bmem[12'(tgt)]), 64'hEE);
      end else begin
        for (int i = 0; i < int'(len); i++)
          chk("R5 R6 copied byte", 64'(bmem[12'(tgt) + 12'(i)]), 64'(m_byte(b_sel, b_off + i)));
        b_off += len; exp_wr = len + 1;
      end
    end else begin
      if (ctl[2]) b_off += len;
      exp_wr = 1;
      if (len != 0) chk("R7 target untouched", 64'(bmem[12'(tgt)]), 64'hEE);
    end
    chk("R5 R7 R9 write beat count", 64'(wr_count), 64'(exp_wr));
    chk("R3 R4 first fetch address", first_addr, p & ~64'h3);
    st = {bmem[12'(p)], bmem[12'(p) + 12'd1], bmem[12'(p) + 12'd2], bmem[12'(p) + 12'd3]};
    chk(is_err ? "R9 error status" : "R8 completion status", 64'(st), is_err ? 64'd1 : 64'd0);
    reg_read(RA_PTR_LO, r); chk("R8 pointer low cleared", r, 0);
    reg_read(RA_PTR_HI, r); chk("R8 pointer high cleared", r, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd7));
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R2 busy after reset", 64'(busy), 0);
    chk("R12 no request after reset", 64'(mem_req_valid), 0);
    reg_read(RA_FEATURE, r);  chk("R1 feature word", r, 64'h2);
    reg_read(RA_PTR_HI, r);   chk("R2 pointer high reset", r, 0);
    reg_read(RA_PTR_LO, r);   chk("R2 pointer low reset", r, 0);
    reg_read(RA_SELECT, r);   chk("R10 selector reset", r, 0);
    // high half loads without starting; lane order readback
    reg_write(RA_PTR_HI, 32'h4433_2211);
    chk("R3 high half does not start", 64'(busy), 0);
    reg_read(RA_PTR_HI, r);   chk("R2 pointer high readback", r, 64'h4433_2211);
    // 64-bit pointer: high value is 0x11223344 (big-endian lanes)
    run_op({32'h1122_3344, 32'h0000_0100}, 32'h2, 32'd5, 64'h400, 0);
    // skip then read from the advanced position
    run_op(64'h140, 32'h4, 32'd3, 64'h480, 0);
    run_op(64'h180, 32'h2, 32'd4, 64'h4C0, 0);
    // read+skip acts as read; error bit in descriptor ignored
    run_op(64'h1C0, 32'h7, 32'd2, 64'h501, 0);
    // past end of smallest item
    set_sel(3);
    run_op(64'h200, 32'h2, 32'd8, 64'h523, 0);
    // selector rewinds
    set_sel(3);
    run_op(64'h240, 32'h2, 32'd3, 64'h542, 0);
    // out-of-range selector reads zeros
    set_sel(5);
    run_op(64'h280, 32'h2, 32'd6, 64'h560, 0);
    // zero length and no-op
    set_sel(1);
    run_op(64'h2C0, 32'h2, 32'd0, 64'h580, 0);
    run_op(64'h300, 32'h0, 32'd7, 64'h590, 0);
    // bus error on first data write
    run_op(64'h340, 32'h2, 32'd4, 64'h1_05A0, 0);
    // writes while busy ignored
    set_sel(0);
    run_op(64'h380, 32'h2, 32'd12, 64'h600, 1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [31:0] c;
      int unsigned pick;
      if ($urandom % 4 == 0) set_sel($urandom % 6);
      pick = $urandom % 5;
      c = (pick == 0) ? 32'h2 : (pick == 1) ? 32'h4 : (pick == 2) ? 32'h6 :
          (pick == 3) ? 32'h0 : 32'h3;
      run_op(64'h100 + 64'(($urandom % 32) * 16), c, 32'($urandom % 25),
             64'h400 + 64'($urandom % 1024), 0);
    end
    chk("R12 request held until ready", 64'(viol), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule